// File: doc/BRIEF.md
# Two-Plane Mesh Route Selector

This block decides, for one router of a two-dimensional mesh, where the head flit of a packet goes next. It takes the router's own coordinates, the destination coordinates carried by the head flit, the routing plane the flit currently travels on, and the input port it entered through. One clock later it presents the chosen output port and the plane for the next hop. Body and tail flits reuse the head's decision elsewhere in the router, so the route is a pure function of these inputs.

A parameter picks one of two routing disciplines. The first is plain dimension-order routing: X is resolved first, then Y, and the plane is passed through untouched. The second uses two planes that obey different turn rules. Plane 0 takes all of its westward hops before any other hop. A packet on plane 0 that must head west after it has already moved east, north or south is moved to plane 1. Plane 1 leaves northward hops until last. Each plane is free of cycles on its own, and packets only ever move from plane 0 to plane 1, so the combined scheme stays deadlock free while allowing a westward turn that plane 0 alone forbids.

Top module: `mesh_route_select`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` is low.
- R2: `outValid` is high in the cycle after `inValid` was high, and low in the cycle after `inValid` was low. The port and plane outputs are registered with it.
- R3: When the destination equals the current node, the output port is Local (code 0) in both modes, and the plane output equals the input plane.
- R4: Port codes are Local 0, East 1, West 2, North 3, South 4. East means increasing X and North means increasing Y. `inFrom` carries the code of the input port the flit entered through, with Local meaning the flit was injected at this node.
- R5: In dimension-order mode, if the X coordinates differ, the port is East when the destination X is larger and West when it is smaller, whatever the Y coordinates are.
- R6: In dimension-order mode with equal X coordinates, the port is North when the destination Y is larger and South when it is smaller. The plane output always equals the input plane.
- R7: In two-plane mode on plane 0, a destination to the west with the flit entering on the Local or East port gives West on plane 0, even when Y also differs.
- R8: In two-plane mode on plane 0, a destination to the west with the flit entering on the West, North or South port gives West on plane 1.
- R9: In two-plane mode on plane 0 with no westward move needed, the port is East if X still differs, otherwise North or South, and the plane stays 0.
- R10: In two-plane mode on plane 1, X is resolved first (East or West), then South. North is chosen only when X is equal and no southward move remains. The plane stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A head flit is being presented |
| curX | input | XW | X coordinate of this router |
| curY | input | YW | Y coordinate of this router |
| dstX | input | XW | Destination X coordinate from the head flit |
| dstY | input | YW | Destination Y coordinate from the head flit |
| inPlane | input | 1 | Current routing plane of the flit |
| inFrom | input | 3 | Input port code the flit entered on |
| outValid | output | 1 | Route result valid |
| outPort | output | 3 | Selected output port code |
| outPlane | output | 1 | Plane to use on the next hop |

## Verification
A wrong comparison between the coordinates would show as a wrong port code in the cycle after the head flit is presented. For example, a South where the dimension order requires East, or a Local for a node that is not yet reached. A fault in the plane logic would show in that same cycle as a plane-0 result for a westward packet that has already turned, or as a packet dropping from plane 1 back to plane 0. Each decision is independent of earlier ones, so every error is visible exactly one cycle after its stimulus and cannot hide behind history.

// File: rtl/route_pkg.sv
package route_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } portE;

  localparam int MODE_DOR  = 0;
  localparam int MODE_TURN = 1;

  // coordinate comparison flags, datapath -> control
  typedef struct packed {
    logic atDest;
    logic needE;
    logic needW;
    logic needN;
    logic needS;
  } cmpT;

  // decision strobes, control -> datapath
  typedef struct packed {
    logic load;
    portE port;
    logic plane;
  } strobeT;
endpackage

// File: rtl/route_datapath.sv
module route_datapath
  import route_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int ROUTE_MODE = MODE_TURN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic          inPlane,
  input  logic [XW-1:0] curX,
  input  logic [YW-1:0] curY,
  input  logic [XW-1:0] dstX,
  input  logic [YW-1:0] dstY,
  input  strobeT        strobe,
  output cmpT           cmp,
  output logic          outValid,
  output portE          outPort,
  output logic          outPlane
);
  // unsigned coordinate comparisons
  always_comb begin
    cmp.needE  = dstX > curX;
    cmp.needW  = dstX < curX;
    cmp.needN  = dstY > curY;
    cmp.needS  = dstY < curY;
    cmp.atDest = (dstX == curX) && (dstY == curY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outPort  <= PORT_LOCAL;
      outPlane <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outPort  <= strobe.port;
        outPlane <= strobe.plane;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  assert_local_at_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && cmp.atDest) |=> (outPort == PORT_LOCAL));
  assert_local_only_at_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !cmp.atDest) |=> (outPort != PORT_LOCAL));

  generate
    if (ROUTE_MODE == MODE_DOR) begin : g_dorChk
      assert_x_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && (cmp.needE || cmp.needW)) |=>
          (outPort == PORT_EAST || outPort == PORT_WEST));
      assert_plane_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> (outPlane == $past(inPlane)));
    end else begin : g_turnChk
      assert_west_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && !inPlane && cmp.needW) |=> (outPort == PORT_WEST));
      assert_plane_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && inPlane) |=> outPlane);
      assert_north_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && inPlane && (cmp.needE || cmp.needW || cmp.needS)) |=>
          (outPort != PORT_NORTH));
    end
  endgenerate
endmodule

// File: rtl/route_control.sv
module route_control
  import route_pkg::*;
#(
  parameter int ROUTE_MODE = MODE_TURN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inPlane,
  input  logic [2:0] inFrom,
  input  cmpT        cmp,
  output strobeT     strobe
);
  portE fromPort;
  logic movedNonWest;

  assign fromPort     = portE'(inFrom);
  // entering on West/North/South means the last hop went east/south/north
  assign movedNonWest = (fromPort == PORT_WEST) || (fromPort == PORT_NORTH) ||
                        (fromPort == PORT_SOUTH);

  generate
    if (ROUTE_MODE == MODE_DOR) begin : g_dor
      always_comb begin
        strobe.load  = inValid;
        strobe.plane = inPlane;
        if (cmp.needE)      strobe.port = PORT_EAST;
        else if (cmp.needW) strobe.port = PORT_WEST;
        else if (cmp.needN) strobe.port = PORT_NORTH;
        else if (cmp.needS) strobe.port = PORT_SOUTH;
        else                strobe.port = PORT_LOCAL;
      end
    end else begin : g_turn
      always_comb begin
        strobe.load  = inValid;
        strobe.plane = inPlane;
        strobe.port  = PORT_LOCAL;
        if (!inPlane) begin
          // plane 0: westward hops first, then X before Y
          if (cmp.needW) begin
            strobe.port  = PORT_WEST;
            strobe.plane = movedNonWest;
          end else if (cmp.needE) strobe.port = PORT_EAST;
          else if (cmp.needN)     strobe.port = PORT_NORTH;
          else if (cmp.needS)     strobe.port = PORT_SOUTH;
        end else begin
          // plane 1: north-bound hops last
          if (cmp.needE)      strobe.port = PORT_EAST;
          else if (cmp.needW) strobe.port = PORT_WEST;
          else if (cmp.needS) strobe.port = PORT_SOUTH;
          else if (cmp.needN) strobe.port = PORT_NORTH;
        end
      end

      assert_switch_on_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && !inPlane && cmp.needW && movedNonWest) |-> strobe.plane);
      assert_stay_plane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && !inPlane && !cmp.needW) |-> !strobe.plane);
    end
  endgenerate

  assert_port_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> (strobe.port inside {PORT_LOCAL, PORT_EAST, PORT_WEST,
                                     PORT_NORTH, PORT_SOUTH}));
endmodule

// File: rtl/mesh_route_select.sv
module mesh_route_select
  import route_pkg::*;
#(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int ROUTE_MODE = MODE_TURN,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic [XW-1:0] curX,
  input  logic [YW-1:0] curY,
  input  logic [XW-1:0] dstX,
  input  logic [YW-1:0] dstY,
  input  logic          inPlane,
  input  logic [2:0]    inFrom,
  output logic          outValid,
  output logic [2:0]    outPort,
  output logic          outPlane
);
  cmpT    cmp;
  strobeT strobe;
  portE   portReg;

  route_control #(.ROUTE_MODE(ROUTE_MODE)) ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inPlane(inPlane),
    .inFrom(inFrom), .cmp(cmp), .strobe(strobe)
  );

  route_datapath #(.XW(XW), .YW(YW), .ROUTE_MODE(ROUTE_MODE)) dp (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inPlane(inPlane),
    .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY),
    .strobe(strobe), .cmp(cmp),
    .outValid(outValid), .outPort(portReg), .outPlane(outPlane)
  );

  assign outPort = portReg;
endmodule

// File: tb/mesh_route_select_test.sv
module mesh_route_select_test;
  localparam int L = 0, E = 1, W = 2, N = 3, S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] curX = '0, curY = '0, dstX = '0, dstY = '0;
  logic inPlane = 1'b0;
  logic [2:0] inFrom = 3'd0;
  logic outValid, outPlane, dValid, dPlane;
  logic [2:0] outPort, dPort;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mesh_route_select #(.MESH_X(8), .MESH_Y(8), .ROUTE_MODE(1)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .curX(curX), .curY(curY),
    .dstX(dstX), .dstY(dstY), .inPlane(inPlane), .inFrom(inFrom),
    .outValid(outValid), .outPort(outPort), .outPlane(outPlane));

  mesh_route_select #(.MESH_X(8), .MESH_Y(8), .ROUTE_MODE(0)) uutDor (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .curX(curX), .curY(curY),
    .dstX(dstX), .dstY(dstY), .inPlane(inPlane), .inFrom(inFrom),
    .outValid(dValid), .outPort(dPort), .outPlane(dPlane));

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // present one head flit, then sample both results one cycle later
  task automatic route(int cx, int cy, int dx, int dy, int pl, int from);
    @(negedge clk);
    curX = 3'(cx); curY = 3'(cy); dstX = 3'(dx); dstY = 3'(dy);
    inPlane = pl[0]; inFrom = 3'(from); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 turn valid", int'(outValid), 1);
    check("R2 dor valid", int'(dValid), 1);
  endtask

  task automatic tReset();
    check("R1 turn idle in reset", int'(outValid), 0);
    check("R1 dor idle in reset", int'(dValid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 turn idle after reset", int'(outValid), 0);
    check("R1 dor idle after reset", int'(dValid), 0);
  endtask

  task automatic tEastFirst();
    route(2, 2, 5, 1, 0, L);
    check("R5 dor east", int'(dPort), E);
    check("R9 turn east plane0", int'(outPort), E);
    check("R9 turn plane0 kept", int'(outPlane), 0);
  endtask

  task automatic tWestInjected();
    route(5, 3, 1, 6, 0, L);
    check("R5 dor west", int'(dPort), W);
    check("R7 turn west", int'(outPort), W);
    check("R7 turn plane0", int'(outPlane), 0);
  endtask

  task automatic tYAxis();
    route(4, 2, 4, 6, 1, L);
    check("R6 dor north", int'(dPort), N);
    check("R6 dor plane passthrough", int'(dPlane), 1);
    check("R10 turn north", int'(outPort), N);
    check("R10 turn plane1", int'(outPlane), 1);
    route(4, 6, 4, 0, 0, L);
    check("R6 dor south", int'(dPort), S);
    check("R6 dor plane passthrough 0", int'(dPlane), 0);
    check("R9 turn south", int'(outPort), S);
    check("R9 turn plane0", int'(outPlane), 0);
  endtask

  task automatic tLocal();
    route(3, 3, 3, 3, 1, N);
    check("R3 dor local", int'(dPort), L);
    check("R3 turn local", int'(outPort), L);
    check("R3 turn plane1", int'(outPlane), 1);
    route(0, 0, 0, 0, 0, W);
    check("R3 dor local origin", int'(dPort), L);
    check("R3 turn local origin", int'(outPort), L);
    check("R3 turn plane0", int'(outPlane), 0);
  endtask

  task automatic tPlaneSwitch();
    route(6, 2, 1, 2, 0, N);
    check("R8 turn west", int'(outPort), W);
    check("R8 turn to plane1", int'(outPlane), 1);
    check("R6 dor west keeps plane", int'(dPlane), 0);
    route(6, 2, 1, 2, 0, E);
    check("R7 west from east port", int'(outPort), W);
    check("R7 stays plane0", int'(outPlane), 0);
    route(7, 7, 0, 0, 0, W);
    check("R8 corner west", int'(outPort), W);
    check("R8 corner plane1", int'(outPlane), 1);
    check("R5 dor corner west", int'(dPort), W);
    route(5, 5, 2, 5, 0, S);
    check("R8 from south port", int'(outPlane), 1);
  endtask

  task automatic tNorthLast();
    route(2, 5, 2, 1, 1, L);
    check("R10 south on plane1", int'(outPort), S);
    route(2, 1, 6, 7, 1, S);
    check("R10 east before north", int'(outPort), E);
    check("R10 plane1 kept", int'(outPlane), 1);
    check("R5 dor east", int'(dPort), E);
    route(6, 3, 1, 7, 1, W);
    check("R10 west before north", int'(outPort), W);
    route(6, 1, 6, 7, 1, W);
    check("R10 north last", int'(outPort), N);
  endtask

  task automatic tIdle();
    @(negedge clk);
    curX = 3'd1; dstX = 3'd6; inValid = 1'b0;
    @(negedge clk);
    check("R2 turn no valid", int'(outValid), 0);
    check("R2 dor no valid", int'(dValid), 0);
  endtask

  initial begin
    tReset();
    tEastFirst();
    tWestInjected();
    tYAxis();
    tLocal();
    tPlaneSwitch();
    tNorthLast();
    tIdle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule